// File: doc/BRIEF.md
# Address Protection Region Checker

This block sits beside the CPU address path and judges each transaction against eight programmable address regions. Each region has a base register and a size register. The base register holds the region's start address and three forbid flags: one for any access, one for writes and one for caching. For each request the checker returns three results one cycle later: whether the access may proceed, whether the target may be cached, and which region, if any, supplied the attributes.

Regions are power-of-two sized and aligned to their size. The size is held as a mask of contiguous ones counted in 64 KB units, and the smallest region is 1 MB. A size mask of zero closes a region. When regions overlap, the lowest-numbered one decides. A fixed internal register window, set by parameter, is never blocked. Software programs the regions through a simple one-cycle register write port.

Top module: `prot_region_checker`

## Requirements
- R1: After synchronous reset all eight regions are closed, rsp_valid is 0, and rsp_allow and rsp_cache are 1.
- R2: A request sampled with req_valid high at a clock edge gives rsp_valid high after that same edge. rsp_valid is low after any edge where req_valid was low.
- R3: Base register layout (cfg_sel=0). Bits [19:0] hold the address from bit 16 upward, and only the bits that exist in the address are compared. Bit 20 forbids all access, bit 21 forbids writes and bit 22 forbids caching. Bits 31:23 are ignored.
- R4: Size register (cfg_sel=1). Its low bits hold the mask (size/64 KB − 1). An address hits an open region when (addr[31:16] XOR base) AND NOT mask is zero.
- R5: For any nonzero size mask, the low four mask bits are treated as ones, so the smallest region is 1 MB.
- R6: Writing a size of zero closes the region. A closed region never hits.
- R7: When several open regions hit, the lowest index supplies the attributes and is reported on rsp_region.
- R8: An address that hits no region gives rsp_allow=1, rsp_cache=1, rsp_hit=0 and rsp_region=0.
- R9: A write is denied when the access-forbid bit or the write-forbid bit of the hitting region is set. A read is denied only by the access-forbid bit.
- R10: On a hit, rsp_cache is the inverse of the cache-forbid bit, whether or not the access is allowed.
- R11: An address inside the internal register window [INT_BASE, INT_BASE + 2^INT_LOG2) is always allowed. The cache and region results are still reported as usual.
- R12: A register write takes effect for requests sampled from the following edge on. A request sampled at the same edge as the write is judged with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the size register |
| cfg_idx | input | 3 | Region index being written |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Transaction address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_cache | output | 1 | Target may be cached |
| rsp_hit | output | 1 | Some open region matched |
| rsp_region | output | 3 | Index of the deciding region |

## Verification
Reads and writes go to the same address inside a write-forbidden region. This separates the two deny rules. A no-access region is also hit by a read, which shows that reads are blocked only by the access flag. Two overlapping regions with different flags are probed where both hit and where only the larger one does, which exposes any priority inversion.

Addresses just inside and just outside a 1 MB region programmed with a one-unit mask pin down the minimum-size rule. A 4 MB region is probed at its last unit and its first outside unit. Probes at the internal window and one unit past it, inside a no-access region, separate the bypass from the region logic. A region is closed in the same cycle as a request to it, then probed again, which fixes when a register write takes effect.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int ATTR_NOACC_BIT = 20;
  localparam int ATTR_NOWR_BIT  = 21;
  localparam int ATTR_NOCACHE_BIT = 22;

  typedef struct packed {
    logic no_cache;
    logic no_write;
    logic no_access;
  } prot_attr_t;
endpackage

// File: rtl/prot_region_file.sv
module prot_region_file
  import prot_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 32,
  parameter int UPPER_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic                              cfg_sel,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [NREG-1:0][UPPER_W-1:0]      base_q,
  output logic [NREG-1:0][UPPER_W-1:0]      mask_q,
  output prot_attr_t [NREG-1:0]             attr_q,
  output logic [NREG-1:0]                   open_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel_hit;
    assign sel_hit = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (sel_hit) begin
        if (cfg_sel) begin
          mask_q[g] <= cfg_wdata[UPPER_W-1:0];
        end else begin
          base_q[g]           <= cfg_wdata[UPPER_W-1:0];
          attr_q[g].no_access <= cfg_wdata[ATTR_NOACC_BIT];
          attr_q[g].no_write  <= cfg_wdata[ATTR_NOWR_BIT];
          attr_q[g].no_cache  <= cfg_wdata[ATTR_NOCACHE_BIT];
        end
      end
    end

    assign open_q[g] = |mask_q[g];
  end

  // R6: a zero size write leaves the region closed on the next cycle
  a_r6_zero_size_closes: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel && (cfg_wdata[UPPER_W-1:0] == '0))
      |=> !open_q[$past(cfg_idx)]);

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match #(
  parameter int NREG     = 8,
  parameter int UPPER_W  = 16,
  parameter int MIN_BITS = 4
) (
  input  logic [UPPER_W-1:0]               addr_hi,
  input  logic [NREG-1:0][UPPER_W-1:0]     base_q,
  input  logic [NREG-1:0][UPPER_W-1:0]     mask_q,
  input  logic [NREG-1:0]                  open_q,
  output logic [NREG-1:0]                  hit_vec
);
  localparam logic [UPPER_W-1:0] MIN_MASK = UPPER_W'((1 << MIN_BITS) - 1);

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    logic [UPPER_W-1:0] eff_mask;
    logic [UPPER_W-1:0] diff;
    assign eff_mask   = mask_q[g] | MIN_MASK;
    assign diff       = (addr_hi ^ base_q[g]) & ~eff_mask;
    assign hit_vec[g] = open_q[g] && (diff == '0);
  end
endmodule

// File: rtl/prot_priority_pick.sv
module prot_priority_pick #(
  parameter int NREG  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NREG-1:0]  hit_vec,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
    any_hit = |hit_vec;
  end
endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
  import prot_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              NREG      = 8,
  parameter int              UNIT_LOG2 = 16,
  parameter int              MIN_LOG2  = 20,
  parameter int              INT_LOG2  = 16,
  parameter logic [31:0]     INT_BASE  = 32'h1400_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic                         cfg_sel,
  input  logic [$clog2(NREG)-1:0]      cfg_idx,
  input  logic [DATA_W-1:0]            cfg_wdata,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_write,
  output logic                         rsp_valid,
  output logic                         rsp_allow,
  output logic                         rsp_cache,
  output logic                         rsp_hit,
  output logic [$clog2(NREG)-1:0]      rsp_region
);
  localparam int IDX_W    = $clog2(NREG);
  localparam int UPPER_W  = ADDR_W - UNIT_LOG2;
  localparam int MIN_BITS = MIN_LOG2 - UNIT_LOG2;

  logic [NREG-1:0][UPPER_W-1:0] base_q;
  logic [NREG-1:0][UPPER_W-1:0] mask_q;
  prot_attr_t [NREG-1:0]        attr_q;
  logic [NREG-1:0]              open_q;
  logic [NREG-1:0]              hit_vec;
  logic                         any_hit;
  logic [IDX_W-1:0]             win_idx;
  prot_attr_t                   win_attr;
  logic                         in_int;
  logic                         deny;
  logic                         cache_ok;

  prot_region_file #(
    .NREG(NREG), .IDX_W(IDX_W), .DATA_W(DATA_W), .UPPER_W(UPPER_W)
  ) u_file (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q), .attr_q(attr_q), .open_q(open_q)
  );

  prot_region_match #(
    .NREG(NREG), .UPPER_W(UPPER_W), .MIN_BITS(MIN_BITS)
  ) u_match (
    .addr_hi(req_addr[ADDR_W-1:UNIT_LOG2]),
    .base_q(base_q), .mask_q(mask_q), .open_q(open_q),
    .hit_vec(hit_vec)
  );

  prot_priority_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  assign win_attr = attr_q[win_idx];
  assign in_int   = (req_addr[ADDR_W-1:INT_LOG2] == INT_BASE[ADDR_W-1:INT_LOG2]);
  assign deny     = any_hit && !in_int &&
                    (win_attr.no_access || (req_write && win_attr.no_write));
  assign cache_ok = !(any_hit && win_attr.no_cache);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b1;
      rsp_cache  <= 1'b1;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow  <= !deny;
        rsp_cache  <= cache_ok;
        rsp_hit    <= any_hit;
        rsp_region <= win_idx;
      end
    end
  end

  // R2: one response per request, one cycle later
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8: a miss is always open and cacheable
  a_r8_miss_open: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_allow && rsp_cache && rsp_region == '0));
  // R11: internal register window is never blocked
  a_r11_int_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_int) |=> rsp_allow);
  // R7: the reported region is one that actually hit
  a_r7_win_is_hit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && any_hit) |-> hit_vec[win_idx]);

endmodule

// File: tb/prot_region_checker_tb.sv
module prot_region_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_cache, rsp_hit;
  logic [2:0]  rsp_region;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       allow;
    logic       cache;
    logic       hit;
    logic [2:0] idx;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] sh_base [8];
  logic [15:0] sh_mask [8];
  logic [2:0]  sh_attr [8]; // {no_cache, no_write, no_access}

  always #4 clk = ~clk; // 125 MHz

  prot_region_checker dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_cache(rsp_cache), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region)
  );

  function automatic exp_t model(input logic [31:0] a, input logic wr, input string r);
    exp_t e;
    logic inint;
    e.hit = 1'b0; e.idx = '0; e.allow = 1'b1; e.cache = 1'b1; e.req = r;
    inint = (a[31:16] == 16'h1400);
    for (int i = 0; i < 8; i++) begin
      if (!e.hit && sh_mask[i] != 16'h0 &&
          (((a[31:16] ^ sh_base[i]) & ~(sh_mask[i] | 16'h000F)) == 16'h0)) begin
        e.hit = 1'b1;
        e.idx = 3'(i);
      end
    end
    if (e.hit) begin
      e.cache = !sh_attr[e.idx][2];
      if (!inint && (sh_attr[e.idx][0] || (wr && sh_attr[e.idx][1])))
        e.allow = 1'b0;
    end
    return e;
  endfunction

  // one cycle of stimulus: optional register write and optional request
  task automatic step(input logic we, input logic sel, input logic [2:0] idx,
                      input logic [31:0] wd, input logic rv,
                      input logic [31:0] a, input logic wr, input string r);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
    req_valid = rv; req_addr = a; req_write = wr;
    if (rv) exp_q.push_back(model(a, wr, r));
    if (we) begin
      if (sel) sh_mask[idx] = wd[15:0];
      else begin
        sh_base[idx] = wd[15:0];
        sh_attr[idx] = {wd[22], wd[21], wd[20]};
      end
    end
  endtask

  task automatic wr_base(input logic [2:0] i, input logic [31:0] d);
    step(1'b1, 1'b0, i, d, 1'b0, 32'h0, 1'b0, "");
  endtask
  task automatic wr_size(input logic [2:0] i, input logic [31:0] d);
    step(1'b1, 1'b1, i, d, 1'b0, 32'h0, 1'b0, "");
  endtask
  task automatic req(input logic [31:0] a, input logic wr, input string r);
    step(1'b0, 1'b0, 3'd0, 32'h0, 1'b1, a, wr, r);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, "");
  endtask

  // monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2: response with no request outstanding");
      end else begin
        e = exp_q.pop_front();
        if (rsp_allow !== e.allow || rsp_cache !== e.cache ||
            rsp_hit !== e.hit || rsp_region !== e.idx) begin
          bad++;
          $display("FAIL %s: actual allow=%b cache=%b hit=%b region=%0d expected allow=%b cache=%b hit=%b region=%0d",
                   e.req, rsp_allow, rsp_cache, rsp_hit, rsp_region,
                   e.allow, e.cache, e.hit, e.idx);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = '0; sh_mask[i] = '0; sh_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b1 || rsp_cache !== 1'b1) begin
      bad++;
      $display("FAIL R1: actual valid=%b allow=%b cache=%b expected 0 1 1",
               rsp_valid, rsp_allow, rsp_cache);
    end
    req(32'h1080_0000, 1'b0, "R1");

    // region 2: 16 MB at 0x1000_0000, write-forbidden
    wr_base(3'd2, 32'h0020_1000);
    wr_size(3'd2, 32'h0000_00FF);
    // region 5: 256 MB at 0x1000_0000, no access, no cache
    wr_base(3'd5, 32'h0050_1000);
    wr_size(3'd5, 32'h0000_0FFF);
    req(32'h1080_0000, 1'b0, "R3 R7");
    req(32'h1080_0000, 1'b1, "R9");
    req(32'h1800_0000, 1'b0, "R9 R10");
    req(32'h1400_0000, 1'b1, "R11");
    req(32'h1401_0000, 1'b0, "R11");
    req(32'h2000_0000, 1'b0, "R8");

    // region 0: one-unit mask expands to 1 MB, junk in bits 31:23
    wr_base(3'd0, 32'hFF80_2000);
    wr_size(3'd0, 32'h0000_0001);
    req(32'h200F_FFFC, 1'b1, "R5 R3");
    req(32'h2010_0000, 1'b0, "R5");

    // region 3: 4 MB
    wr_base(3'd3, 32'h0000_4000);
    wr_size(3'd3, 32'h0000_003F);
    req(32'h403F_0000, 1'b1, "R4");
    req(32'h4040_0000, 1'b1, "R4");

    // region 7: cache-forbidden only
    wr_base(3'd7, 32'h0040_3000);
    wr_size(3'd7, 32'h0000_000F);
    req(32'h3000_0040, 1'b1, "R10");

    // R12: close region 7 in the same cycle as a request to it
    step(1'b1, 1'b1, 3'd7, 32'h0, 1'b1, 32'h3000_0000, 1'b0, "R12");
    req(32'h3000_0000, 1'b0, "R12 R6");

    // R6: close region 5, its former area becomes open
    wr_size(3'd5, 32'h0);
    req(32'h1800_0000, 1'b1, "R6");
    req(32'h1080_0000, 1'b1, "R6 R7");

    idle();
    idle();
    idle();
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2: actual %0d responses missing expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2: watchdog expired actual hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule